// File: doc/BRIEF.md
# Speculative Load Violation Detector

This block sits beside the load pipeline of an out-of-order core that lets loads read the cache before every older store has resolved its address. Each load that has executed is written into a load queue together with its age tag, its word address and, when its data came from a pending store rather than the cache, the age of that store. When a store commits, its address and age are compared in parallel against every queued load. A load that is younger than the store, has the same address and did not already take its data from this store or a later one read a stale value. It is marked.

The mark has no immediate effect. Loads leave the queue in program order through a retire port. When a marked load reaches the head and is retired, the block raises a one-cycle flush request that carries the age of the offending load. It then empties the queue, because that load and everything younger is refetched. Unmarked loads retire silently. Age tags carry an extra wrap bit so that ordering stays correct when the tag counter rolls over.

Top module: `ld_order_guard`

## Requirements
- R1: After reset `flush_vld` is 0 and the queue is empty, so a retire request produces no flush.
- R2: A committing store whose address equals that of a queued, non-forwarded load that is younger than the store marks that load. When the load is retired, `flush_vld` is 1 for exactly the cycle after the retire edge, with `flush_age` equal to the load's age tag.
- R3: A committing store whose address differs from that of a load leaves the load unmarked. Its retire produces no flush.
- R4: A load whose age tag is older than or equal to the committing store's age tag is never marked by that store.
- R5: A load with `ld_fwd`=1 is not marked by a store whose age is equal to or older than `ld_fwd_age`. It is marked when `ld_fwd_age` is older than the store.
- R6: Age tags are AGE_W bits, with the top bit as a wrap bit. When the wrap bits are equal, the smaller low part is older. When they differ, the larger low part is older.
- R7: A flush invalidates the violating load and every load behind it, so later retires produce no flush until new loads are written.
- R8: A retire request while the queue is empty has no effect.
- R9: A load write while the queue holds DEPTH entries is dropped and does not disturb stored loads.
- R10: Loads retire oldest first. A marked load has no effect while older unmarked loads ahead of it retire.
- R11: A load written in the same cycle as a store commit is compared against that store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_vld | input | 1 | Write an executed load into the queue |
| ld_age | input | AGE_W | Age tag of the load, with wrap bit |
| ld_addr | input | ADDR_W | Word address the load read |
| ld_fwd | input | 1 | Load data came from a pending store |
| ld_fwd_age | input | AGE_W | Age tag of the store that supplied the data |
| st_vld | input | 1 | A store commits this cycle |
| st_age | input | AGE_W | Age tag of the committing store |
| st_addr | input | ADDR_W | Word address of the committing store |
| ret_vld | input | 1 | Retire the oldest queued load |
| flush_vld | output | 1 | One-cycle pipeline flush request |
| flush_age | output | AGE_W | Age tag of the load that caused the flush |

## Verification
The stimulus goes after the age compare at its edges. It covers a load equal in age to the store, and pairs that straddle the tag wrap in both directions. A design that compares raw tags would flush on the older load or miss the younger one. The forwarding exemption is tested from the same store, a younger store and an older store, which catches an inverted or inclusive age test. A queue with a marked load behind clean ones checks that the flush waits for the head and clears the tail. A design that did not clear the tail would flush a second time. A full queue is offered one more load at an address that a store then hits. A design that accepted it would overwrite the head and flush on the first retire.

// File: rtl/lq_pkg.sv
package lq_pkg;

   // True when tag a is older than tag b. Bit msb is the wrap bit.
   function automatic logic age_older(input logic [31:0] a,
                                      input logic [31:0] b,
                                      input int unsigned msb);
      logic [31:0] low_mask;
      low_mask = (32'd1 << msb) - 32'd1;
      if (a[msb] == b[msb]) return (a & low_mask) < (b & low_mask);
      else                  return (a & low_mask) > (b & low_mask);
   endfunction

endpackage

// File: rtl/lq_hit.sv
module lq_hit #(
   parameter int ADDR_W = 32,
   parameter int AGE_W  = 7
) (
   input  logic              e_vld,
   input  logic [AGE_W-1:0]  e_age,
   input  logic [ADDR_W-1:0] e_addr,
   input  logic              e_fwd,
   input  logic [AGE_W-1:0]  e_fwd_age,
   input  logic              st_vld,
   input  logic [AGE_W-1:0]  st_age,
   input  logic [ADDR_W-1:0] st_addr,
   output logic              hit
);
   import lq_pkg::*;

   logic st_before_ld;
   logic fwd_stale;

   always_comb begin
      st_before_ld = age_older(32'(st_age), 32'(e_age), AGE_W - 1);
      fwd_stale    = !e_fwd || age_older(32'(e_fwd_age), 32'(st_age), AGE_W - 1);
      hit          = e_vld && st_vld && (e_addr == st_addr) && st_before_ld && fwd_stale;
   end
endmodule

// File: rtl/lq_ptrs.sv
module lq_ptrs #(
   parameter int DEPTH = 32,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic             clear,
   output logic [PTR_W-1:0] head,
   output logic [PTR_W-1:0] tail,
   output logic [PTR_W:0]   cnt,
   output logic             full,
   output logic             empty
);
   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         head <= '0;
         tail <= '0;
         cnt  <= '0;
      end else begin
         if (push) tail <= tail + 1'b1;
         if (pop)  head <= head + 1'b1;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign full  = (cnt == (PTR_W + 1)'(DEPTH));
   assign empty = (cnt == '0);
endmodule

// File: rtl/ld_order_guard.sv
module ld_order_guard #(
   parameter int DEPTH  = 32,
   parameter int ADDR_W = 32,
   parameter int AGE_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_vld,
   input  logic [AGE_W-1:0]  ld_age,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic              ld_fwd,
   input  logic [AGE_W-1:0]  ld_fwd_age,
   input  logic              st_vld,
   input  logic [AGE_W-1:0]  st_age,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic              ret_vld,
   output logic              flush_vld,
   output logic [AGE_W-1:0]  flush_age
);
   localparam int PTR_W = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (AGE_W < 2 || AGE_W > 32) begin : g_bad_age
      $error("AGE_W must be between 2 and 32");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be positive");
   end

   logic [PTR_W-1:0] head, tail;
   logic [PTR_W:0]   lq_cnt;
   logic             lq_full, lq_empty;
   logic             accept, pop, flush_now, hit_in;

   logic              e_vld     [DEPTH];
   logic              e_mark    [DEPTH];
   logic              e_hit     [DEPTH];
   logic [AGE_W-1:0]  e_age     [DEPTH];
   logic [ADDR_W-1:0] e_addr    [DEPTH];
   logic              e_fwd     [DEPTH];
   logic [AGE_W-1:0]  e_fwd_age [DEPTH];

   assign pop       = ret_vld && !lq_empty;
   assign flush_now = pop && (e_mark[head] || e_hit[head]);
   assign accept    = ld_vld && !lq_full && !flush_now;

   lq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (accept),
      .pop   (pop),
      .clear (flush_now),
      .head  (head),
      .tail  (tail),
      .cnt   (lq_cnt),
      .full  (lq_full),
      .empty (lq_empty)
   );

   // Incoming load is checked against a store committing in the same cycle.
   lq_hit #(.ADDR_W(ADDR_W), .AGE_W(AGE_W)) u_hit_in (
      .e_vld     (ld_vld),
      .e_age     (ld_age),
      .e_addr    (ld_addr),
      .e_fwd     (ld_fwd),
      .e_fwd_age (ld_fwd_age),
      .st_vld    (st_vld),
      .st_age    (st_age),
      .st_addr   (st_addr),
      .hit       (hit_in)
   );

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic              vld_q, mark_q, fwd_q;
      logic [AGE_W-1:0]  age_q, fwd_age_q;
      logic [ADDR_W-1:0] addr_q;
      logic              wr_here, rd_here;

      assign wr_here = accept && (tail == PTR_W'(i));
      assign rd_here = pop && (head == PTR_W'(i));

      lq_hit #(.ADDR_W(ADDR_W), .AGE_W(AGE_W)) u_hit (
         .e_vld     (vld_q),
         .e_age     (age_q),
         .e_addr    (addr_q),
         .e_fwd     (fwd_q),
         .e_fwd_age (fwd_age_q),
         .st_vld    (st_vld),
         .st_age    (st_age),
         .st_addr   (st_addr),
         .hit       (e_hit[i])
      );

      always_ff @(posedge clk) begin
         if (!rst_n || flush_now) begin
            vld_q  <= 1'b0;
            mark_q <= 1'b0;
         end else if (wr_here) begin
            vld_q  <= 1'b1;
            mark_q <= hit_in;
         end else if (rd_here) begin
            vld_q  <= 1'b0;
            mark_q <= 1'b0;
         end else if (e_hit[i]) begin
            mark_q <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            age_q     <= '0;
            addr_q    <= '0;
            fwd_q     <= 1'b0;
            fwd_age_q <= '0;
         end else if (wr_here) begin
            age_q     <= ld_age;
            addr_q    <= ld_addr;
            fwd_q     <= ld_fwd;
            fwd_age_q <= ld_fwd_age;
         end
      end

      assign e_vld[i]     = vld_q;
      assign e_mark[i]    = mark_q;
      assign e_age[i]     = age_q;
      assign e_addr[i]    = addr_q;
      assign e_fwd[i]     = fwd_q;
      assign e_fwd_age[i] = fwd_age_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flush_vld <= 1'b0;
         flush_age <= '0;
      end else begin
         flush_vld <= flush_now;
         if (flush_now) flush_age <= e_age[head];
      end
   end
endmodule

// File: rtl/ld_order_guard_chk.sv
module ld_order_guard_chk #(
   parameter int DEPTH = 32,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input logic           clk,
   input logic           rst_n,
   input logic           ld_vld,
   input logic           st_vld,
   input logic           ret_vld,
   input logic           flush_vld,
   input logic [PTR_W:0] cnt,
   input logic           full
);
   logic seen_st;

   always_ff @(posedge clk) begin
      if (!rst_n)      seen_st <= 1'b0;
      else if (st_vld) seen_st <= 1'b1;
   end

   p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      flush_vld |=> !flush_vld);

   p_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      flush_vld |-> $past(ret_vld));

   p_needs_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
      flush_vld |-> seen_st);

   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flush_vld |-> cnt == '0);

   p_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_vld && cnt == '0) |=> !flush_vld);

   p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_vld && full && !ret_vld) |=> cnt == $past(cnt));
endmodule

bind ld_order_guard ld_order_guard_chk #(.DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ld_vld    (ld_vld),
   .st_vld    (st_vld),
   .ret_vld   (ret_vld),
   .flush_vld (flush_vld),
   .cnt       (lq_cnt),
   .full      (lq_full)
);

// File: tb/sim_ld_order_guard.sv
`timescale 1ns/1ps
module sim_ld_order_guard;
   localparam int DEPTH  = 32;
   localparam int ADDR_W = 32;
   localparam int AGE_W  = 7;
   localparam int VW     = 87;
   localparam int NVEC   = 10;
   localparam int WATCHDOG = 20000;

   // {ld_age, ld_addr, fwd, fwd_age, st_age, st_addr, expect_flush}
   localparam logic [VW-1:0] VEC [NVEC] = '{
      {7'h05, 32'h100, 1'b0, 7'h00, 7'h03, 32'h100, 1'b1},  // R2 younger hit
      {7'h05, 32'h104, 1'b0, 7'h00, 7'h03, 32'h100, 1'b0},  // R3 other address
      {7'h02, 32'h100, 1'b0, 7'h00, 7'h03, 32'h100, 1'b0},  // R4 older load
      {7'h05, 32'h100, 1'b0, 7'h00, 7'h05, 32'h100, 1'b0},  // R4 equal age
      {7'h05, 32'h100, 1'b1, 7'h03, 7'h03, 32'h100, 1'b0},  // R5 fwd same store
      {7'h06, 32'h100, 1'b1, 7'h04, 7'h03, 32'h100, 1'b0},  // R5 fwd younger store
      {7'h06, 32'h100, 1'b1, 7'h01, 7'h03, 32'h100, 1'b1},  // R5 fwd older store
      {7'h41, 32'h200, 1'b0, 7'h00, 7'h3E, 32'h200, 1'b1},  // R6 load past wrap
      {7'h3E, 32'h200, 1'b0, 7'h00, 7'h41, 32'h200, 1'b0},  // R6 store past wrap
      {7'h02, 32'h200, 1'b0, 7'h00, 7'h7F, 32'h200, 1'b1}   // R6 second wrap
   };

   logic              clk = 1'b0;
   logic              rst_n;
   logic              ld_vld, ld_fwd, st_vld, ret_vld;
   logic [AGE_W-1:0]  ld_age, ld_fwd_age, st_age;
   logic [ADDR_W-1:0] ld_addr, st_addr;
   logic              flush_vld;
   logic [AGE_W-1:0]  flush_age;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   ld_order_guard #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .AGE_W(AGE_W)) u0 (
      .clk(clk), .rst_n(rst_n),
      .ld_vld(ld_vld), .ld_age(ld_age), .ld_addr(ld_addr),
      .ld_fwd(ld_fwd), .ld_fwd_age(ld_fwd_age),
      .st_vld(st_vld), .st_age(st_age), .st_addr(st_addr),
      .ret_vld(ret_vld), .flush_vld(flush_vld), .flush_age(flush_age)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      ld_vld = 0; ld_fwd = 0; st_vld = 0; ret_vld = 0;
   endtask

   task automatic push(input logic [AGE_W-1:0] a, input logic [ADDR_W-1:0] ad,
                       input logic f, input logic [AGE_W-1:0] fa);
      idle();
      ld_vld = 1; ld_age = a; ld_addr = ad; ld_fwd = f; ld_fwd_age = fa;
      tick();
      idle();
   endtask

   task automatic commit(input logic [AGE_W-1:0] a, input logic [ADDR_W-1:0] ad);
      idle();
      st_vld = 1; st_age = a; st_addr = ad;
      tick();
      idle();
   endtask

   task automatic retire();
      idle();
      ret_vld = 1;
      tick();
      idle();
   endtask

   task automatic check(input string req, input logic ev, input logic [AGE_W-1:0] ea);
      checks++;
      if (flush_vld !== ev || (ev && flush_age !== ea)) begin
         fails++;
         $display("FAIL %s: flush_vld=%0b flush_age=%h expected flush_vld=%0b flush_age=%h",
                  req, flush_vld, flush_age, ev, ea);
      end
   endtask

   initial begin
      idle();
      ld_age = '0; ld_addr = '0; ld_fwd_age = '0; st_age = '0; st_addr = '0;
      rst_n = 0;
      repeat (3) tick();
      rst_n = 1;
      tick();

      // R1: reset state
      check("R1", 1'b0, '0);
      // R8: retire on empty queue
      retire();
      check("R8", 1'b0, '0);

      for (int v = 0; v < NVEC; v++) begin
         push(VEC[v][86:80], VEC[v][79:48], VEC[v][47], VEC[v][46:40]);
         commit(VEC[v][39:33], VEC[v][32:1]);
         retire();
         check($sformatf("R2-R6 vector %0d", v), VEC[v][0], VEC[v][86:80]);
      end

      // R10 / R7: marked loads behind a clean one
      push(7'h10, 32'h200, 0, 0);
      push(7'h11, 32'h300, 0, 0);
      push(7'h12, 32'h300, 0, 0);
      commit(7'h09, 32'h300);
      retire();
      check("R10", 1'b0, '0);
      retire();
      check("R2 head flush", 1'b1, 7'h11);
      retire();
      check("R7 tail cleared", 1'b0, '0);
      push(7'h20, 32'h400, 0, 0);
      retire();
      check("R7 queue reusable", 1'b0, '0);

      // R11: load and store in the same cycle
      idle();
      ld_vld = 1; ld_age = 7'h30; ld_addr = 32'h500;
      st_vld = 1; st_age = 7'h2F; st_addr = 32'h500;
      tick();
      idle();
      retire();
      check("R11", 1'b0 | 1'b1, 7'h30);

      // R9: write into a full queue is dropped
      for (int k = 1; k <= DEPTH; k++) push(AGE_W'(k), 32'h1000 + 32'(k), 0, 0);
      push(7'h21, 32'h9000, 0, 0);
      commit(7'h00, 32'h9000);
      begin
         bit seen = 1'b0;
         for (int k = 0; k <= DEPTH; k++) begin
            retire();
            if (flush_vld) seen = 1'b1;
         end
         checks++;
         if (seen) begin
            fails++;
            $display("FAIL R9: flush seen=1 expected flush seen=0");
         end
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule